// File: doc/BRIEF.md
# Line-Restricted Galloping and Walking RAM Tester

This block sequences a functional test over a single-port, bit-wide RAM arranged as a grid of rows and columns. One test line, either the column or the row through a chosen base cell, is exercised around each base cell in turn. The block first writes a uniform background to the whole array. It then visits every cell as the base and writes the complement of the background there. Next it reads every cell on the base cell's line, and finally writes the background back into the base.

In the galloping variant, each line read is followed by a read of the base cell. In the walking variant, the base is read once after the whole line. The full procedure runs twice, first with a background of 0 and then with a background of 1.

The RAM answers a read on the clock edge after the request. The block compares each returned bit with the value it expects. The first mismatch is latched as a sticky failure, together with the base address and the address that was read. When the run ends, `done` rises and stays high until the next start. `pass_ok` reports a clean run.

Top module: `galwalk_line_tester`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `mem_en` are all 0.
- R2: A `start` pulse seen while idle makes `busy` high on the next cycle and latches `walk_mode` and `row_axis`. A `start` pulse seen while busy is ignored, and the run in progress keeps its mode and its length.
- R3: Each pass opens with one write to every address from 0 upward. The written value is the background, which is 0 in the first pass and 1 in the second.
- R4: For each base address in ascending order, the block performs three steps. It writes the complement of the background to the base. It reads each cell of the base's line in ascending line index, and the base itself is one of these cells. It then writes the background back to the base. A line read expects the complement at the base address and the background at every other address.
- R5: In galloping mode (`walk_mode`=0), every line read is followed directly by a base read that expects the complement. A run is then 6n+4nL operations long, where n is the number of cells and L is the length of the line.
- R6: In walking mode (`walk_mode`=1), a single base read follows the last line read. A run is then 8n+2nL operations long.
- R7: The address is row*COLS+col, with the column in the low COL_W bits. The column axis (`row_axis`=0) holds the column fixed and steps the row, so L is ROWS. The row axis (`row_axis`=1) holds the row fixed and steps the column, so L is COLS.
- R8: `mem_rdata` is compared on the edge after a read request. The first mismatch sets `fail`, which stays set until the next start. The same mismatch records the base address in `fail_base` and the address read in `fail_addr`.
- R9: `done` rises on the cycle after the last operation and holds until the next start. It is never high together with `busy`. `pass_ok` is `done` and not `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| walk_mode | input | 1 | 0 selects the galloping form, 1 selects the walking form |
| row_axis | input | 1 | 0 tests along the column, 1 tests along the row |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until the next start |
| pass_ok | output | 1 | Finished with no mismatch |
| fail | output | 1 | Sticky mismatch flag |
| fail_base | output | ROW_W+COL_W | Base address at the first mismatch |
| fail_addr | output | ROW_W+COL_W | Address read at the first mismatch |
| mem_en | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ROW_W+COL_W | RAM address |
| mem_wdata | output | 1 | RAM write data |
| mem_rdata | input | 1 | RAM read data, valid one cycle after a read request |

## Verification
The assertions assume that `start` is a short pulse. They also assume that `mem_rdata` comes from a RAM that returns the value stored at the requested address exactly one edge after the request. The bench drives `start` only at negative edges and holds it for one cycle. It models the RAM with that fixed one-edge latency. The only deviation the bench introduces is a deliberate coupling between two cells of one column, where writing 1 to the aggressor forces the victim to 1. This fault is switched on only in the runs that expect a failure.

// File: rtl/galwalk_line_tester.sv
module galwalk_line_tester #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   walk_mode,
  input  logic                   row_axis,
  output logic                   busy,
  output logic                   done,
  output logic                   pass_ok,
  output logic                   fail,
  output logic [ROW_W+COL_W-1:0] fail_base,
  output logic [ROW_W+COL_W-1:0] fail_addr,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [ROW_W+COL_W-1:0] mem_addr,
  output logic                   mem_wdata,
  input  logic                   mem_rdata
);
  localparam int AW   = ROW_W + COL_W;
  localparam int KW   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;
  localparam logic [AW-1:0] A_LAST   = {AW{1'b1}};
  localparam logic [KW-1:0] K_COLAX  = KW'(ROWS - 1);
  localparam logic [KW-1:0] K_ROWAX  = KW'(COLS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FILL, S_SETB, S_SWPV, S_SWPB, S_CHKB, S_RSTB
  } st_t;

  st_t           st;
  logic          bg, walk_q, row_q;
  logic [AW-1:0] base, victim;
  logic [KW-1:0] k, k_last;
  logic          rd_pend, rd_exp;
  logic [AW-1:0] rd_addr, rd_base;
  logic          exp_now, go;

  assign go      = start && (st == S_IDLE);
  assign k_last  = row_q ? K_ROWAX : K_COLAX;
  assign victim  = row_q ? {base[AW-1:COL_W], k[COL_W-1:0]}
                         : {k[ROW_W-1:0], base[COL_W-1:0]};

  assign busy      = (st != S_IDLE);
  assign mem_en    = busy;
  assign mem_we    = (st == S_FILL) || (st == S_SETB) || (st == S_RSTB);
  assign mem_addr  = (st == S_SWPV) ? victim : base;
  assign mem_wdata = (st == S_SETB) ? ~bg : bg;
  assign exp_now   = ((st == S_SWPV) && (victim != base)) ? bg : ~bg;
  assign pass_ok   = done && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bg <= 1'b0;
      walk_q <= 1'b0;
      row_q <= 1'b0;
      base <= '0;
      k <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st <= S_FILL;
          bg <= 1'b0;
          base <= '0;
          walk_q <= walk_mode;
          row_q <= row_axis;
          done <= 1'b0;
        end
        S_FILL: begin
          base <= base + 1'b1;
          if (base == A_LAST) st <= S_SETB;
        end
        S_SETB: begin
          k <= '0;
          st <= S_SWPV;
        end
        S_SWPV: begin
          if (!walk_q) st <= S_SWPB;
          else if (k == k_last) st <= S_CHKB;
          else k <= k + 1'b1;
        end
        S_SWPB: begin
          if (k == k_last) st <= S_RSTB;
          else begin
            k <= k + 1'b1;
            st <= S_SWPV;
          end
        end
        S_CHKB: st <= S_RSTB;
        S_RSTB: begin
          base <= base + 1'b1;
          if (base != A_LAST) st <= S_SETB;
          else if (!bg) begin
            bg <= 1'b1;
            st <= S_FILL;
          end else begin
            st <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_exp <= 1'b0;
      rd_addr <= '0;
      rd_base <= '0;
      fail <= 1'b0;
      fail_base <= '0;
      fail_addr <= '0;
    end else begin
      rd_pend <= mem_en && !mem_we;
      rd_exp <= exp_now;
      rd_addr <= mem_addr;
      rd_base <= base;
      if (go) fail <= 1'b0;
      else if (rd_pend && (mem_rdata != rd_exp) && !fail) begin
        fail <= 1'b1;
        fail_base <= rd_base;
        fail_addr <= rd_addr;
      end
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_fill_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && base != A_LAST) |=> (mem_we && mem_addr == AW'($past(mem_addr) + 1'b1)));
  p_gallop_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWPV && !walk_q) |=> (mem_en && !mem_we && mem_addr == $past(base)));
  p_walk_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWPV && walk_q && k == k_last) |=> (!mem_we && mem_addr == $past(base)));
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/test_galwalk_line_tester.sv
`timescale 1ns/1ps
module test_galwalk_line_tester;
  localparam int ROW_W = 2, COL_W = 3, AW = ROW_W + COL_W;
  localparam int N = 1 << AW;
  localparam int AGG = 10, VIC = 26;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, walk_mode = 1'b0, row_axis = 1'b0;
  logic busy, done, pass_ok, fail, mem_en, mem_we, mem_wdata, mem_rdata;
  logic [AW-1:0] fail_base, fail_addr, mem_addr;

  always #2 clk = ~clk;

  galwalk_line_tester #(.ROW_W(ROW_W), .COL_W(COL_W)) i_galwalk_line_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .walk_mode(walk_mode), .row_axis(row_axis),
    .busy(busy), .done(done), .pass_ok(pass_ok), .fail(fail),
    .fail_base(fail_base), .fail_addr(fail_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic ram [0:N-1];
  logic fault_on = 1'b0;
  always_ff @(posedge clk) begin
    if (mem_en && mem_we) begin
      ram[mem_addr] <= mem_wdata;
      if (fault_on && int'(mem_addr) == AGG && mem_wdata) ram[VIC] <= 1'b1;
    end
    if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
  end

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  typedef struct { int cnt; bit f; int b; int a; string req; } exp_t;
  exp_t sb[$];

  int ops = 0;
  logic busy_q = 1'b0, done_q = 1'b0;
  int lg_a [0:2047];
  bit lg_w [0:2047];
  bit lg_d [0:2047];

  always @(negedge clk) begin
    if (busy && !busy_q) ops = 0;
    if (mem_en && ops < 2048) begin
      lg_a[ops] = int'(mem_addr);
      lg_w[ops] = mem_we;
      lg_d[ops] = mem_wdata;
      ops++;
    end
    if (done && !done_q && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(ops == e.cnt, e.req, $sformatf("op count actual %0d expected %0d", ops, e.cnt));
      chk(fail == e.f, "R8", $sformatf("fail actual %0b expected %0b", fail, e.f));
      chk(pass_ok == !e.f, "R9", $sformatf("pass_ok actual %0b expected %0b", pass_ok, !e.f));
      if (e.f) begin
        chk(int'(fail_base) == e.b, "R8", $sformatf("fail_base actual %0d expected %0d", fail_base, e.b));
        chk(int'(fail_addr) == e.a, "R8", $sformatf("fail_addr actual %0d expected %0d", fail_addr, e.a));
      end
    end
    busy_q = busy;
    done_q = done;
  end

  task automatic run(input bit w, input bit r, input int cnt, input bit f, input int b,
                     input int a, input string req, input bit poke);
    exp_t e;
    e.cnt = cnt; e.f = f; e.b = b; e.a = a; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    walk_mode = w; row_axis = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", $sformatf("busy after start actual %0b expected 1", busy));
    chk(done == 1'b0, "R9", $sformatf("done after start actual %0b expected 0", done));
    if (poke) begin
      repeat (50) @(negedge clk);
      walk_mode = ~w; row_axis = ~r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    if (!done) chk(1'b0, req, "watchdog: done actual 0 expected 1");
    @(negedge clk);
    chk(done && !busy, "R9", $sformatf("done held actual %0b expected 1", done));
  endtask

  function automatic string opstr(input int i);
    return $sformatf("op%0d we=%0b addr=%0d d=%0b", i, lg_w[i], lg_a[i], lg_d[i]);
  endfunction

  initial begin
    #(200000 * 4);
    chk(1'b0, "R9", "global watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_en, "R1",
        $sformatf("reset busy=%0b done=%0b fail=%0b en=%0b expected all 0", busy, done, fail, mem_en));
    rst_n = 1'b1;
    @(negedge clk);

    run(1'b0, 1'b0, 6*N + 4*N*4, 1'b0, 0, 0, "R5", 1'b1);
    chk(lg_w[0] && lg_a[0] == 0 && !lg_d[0], "R3", {opstr(0), " expected write addr 0 data 0"});
    chk(lg_w[N-1] && lg_a[N-1] == N-1, "R3", {opstr(N-1), " expected write addr 31"});
    chk(lg_w[N] && lg_a[N] == 0 && lg_d[N], "R4", {opstr(N), " expected write addr 0 data 1"});
    chk(!lg_w[N+1] && lg_a[N+1] == 0, "R4", {opstr(N+1), " expected read addr 0"});
    chk(!lg_w[N+3] && lg_a[N+3] == 8, "R7", {opstr(N+3), " expected read addr 8"});
    chk(!lg_w[N+4] && lg_a[N+4] == 0, "R5", {opstr(N+4), " expected read base 0"});
    chk(!lg_w[N+7] && lg_a[N+7] == 24, "R7", {opstr(N+7), " expected read addr 24"});
    chk(lg_w[N+9] && lg_a[N+9] == 0 && !lg_d[N+9], "R4", {opstr(N+9), " expected write addr 0 data 0"});
    chk(lg_w[352] && lg_a[352] == 0 && lg_d[352], "R3", {opstr(352), " expected second fill addr 0 data 1"});

    run(1'b0, 1'b1, 6*N + 4*N*8, 1'b0, 0, 0, "R7", 1'b0);
    chk(!lg_w[N+3] && lg_a[N+3] == 1, "R7", {opstr(N+3), " expected read addr 1"});

    run(1'b1, 1'b0, 8*N + 2*N*4, 1'b0, 0, 0, "R6", 1'b0);
    chk(!lg_w[N+2] && lg_a[N+2] == 8, "R6", {opstr(N+2), " expected read addr 8"});
    chk(!lg_w[N+5] && lg_a[N+5] == 0, "R6", {opstr(N+5), " expected base read addr 0"});
    chk(lg_w[N+6] && lg_a[N+6] == 0 && !lg_d[N+6], "R4", {opstr(N+6), " expected restore addr 0"});

    run(1'b1, 1'b1, 8*N + 2*N*8, 1'b0, 0, 0, "R6", 1'b0);

    fault_on = 1'b1;
    run(1'b0, 1'b0, 6*N + 4*N*4, 1'b1, AGG, VIC, "R8", 1'b0);
    run(1'b1, 1'b0, 8*N + 2*N*4, 1'b1, AGG, VIC, "R8", 1'b0);
    run(1'b0, 1'b1, 6*N + 4*N*8, 1'b1, 24, VIC, "R8", 1'b0);
    fault_on = 1'b0;
    run(1'b0, 1'b0, 6*N + 4*N*4, 1'b0, 0, 0, "R8", 1'b0);

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9", $sformatf("pending results actual %0d expected 0", sb.size()));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule